// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit produces a low-precision estimate of 1/sqrt(x) for a 32-bit operand. It serves as the seed for vector estimate instructions. Software or a refinement datapath then improves the seed with its own iteration steps. Two operand formats are accepted, chosen per request. The first is IEEE single precision. The second is an unsigned fixed-point word that holds a value in [0.25, 1).

In float mode the operand is classified first. NaNs, zeros, negative values and positive infinity each produce a fixed result and their own exception flags. Every other operand takes the estimate path. Its significand is scaled into one of two ranges, chosen by the parity of the exponent. A 7-bit index then selects an entry from a 256-entry constant table. Each entry is a 9-bit estimate with an implicit leading one. The result exponent is derived from the input exponent by subtraction and halving. The fixed-point mode uses the same table and chooses its range from the two top operand bits.

A request is one `in_valid` cycle. Its result, together with the two flag pulses, appears one clock later with `out_valid`.

Top module: `rsqrt_est`

## Requirements
- R1: In float mode (`in_mode`=0), a NaN operand (exponent field all ones, fraction nonzero) gives 0x7FC00000. `out_invalid` is raised only when fraction bit 22 of that NaN is 0, meaning the NaN is signaling.
- R2: In float mode, +0 or -0 gives an infinity with the operand's sign (0x7F800000 or 0xFF800000) and raises `out_divzero`.
- R3: In float mode, any other operand with bit 31 set gives 0x7FC00000 and raises `out_invalid`. This covers negative infinity, negative normals and negative subnormals.
- R4: In float mode, +infinity gives 0x00000000 with no flag.
- R5: In float mode, every other positive operand takes the estimate path, including subnormals, which use exponent field E=0. The range selection depends on the exponent parity:
  - If the exponent field is odd, q = 128 + fraction[22:16] and D = 512.
  - If the exponent field is even, q = 128 + fraction[22:16] and D = 256.
- R6: The estimate is s = floor(256/sqrt((q+0.5)/D) + 0.5), which always lies in 256..511. The float result has sign 0 and fraction {s[7:0], 15'b0}.
- R7: The float result's exponent field is (380 - E) >> 1, where E is the input exponent field.
- R8: In fixed mode (`in_mode`=1), an operand whose bits 31 and 30 are both 0 gives 0xFFFFFFFF. Fixed mode never raises either flag.
- R9: In fixed mode, other operands give {1'b1, s[7:0], 23'b0}, with s computed as in R6. The range selection depends on bit 31:
  - If bit 31 is set, q = 128 + op[30:24] and D = 256.
  - If bit 31 is clear, q = 128 + op[29:23] and D = 512.
- R10: `out_valid` is high exactly in the cycle after each `in_valid` cycle and low after reset. `out_invalid` and `out_divzero` are never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 1 | 0 selects single precision, 1 selects unsigned fixed point |
| in_op | input | 32 | Operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Estimate or special value |
| out_invalid | output | 1 | Invalid-operation pulse |
| out_divzero | output | 1 | Divide-by-zero pulse |

## Verification
The block's widths and table depth are fixed constants in its package, so the bench builds the single default configuration. That configuration still reaches all 256 table entries. Random normal operands sweep both exponent parities and all 7-bit index values. Random fixed-point words cover both halves of the table through the bit-31 split. Directed operands pin down the corner cases:
- signaling versus quiet NaNs;
- signed zeros;
- negative infinity;
- subnormals with exponent 0;
- the saturating fixed-point inputs;
- the table ends at q=128, where the estimate is 511 or 361.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int WORD_W   = 32;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int IDX_W    = 7;
  localparam int ROM_AW   = IDX_W + 1;
  localparam int ROM_DEPTH = 1 << ROM_AW;
  localparam int EST_W    = 8;
  localparam int EXP_BASE = 380;
  localparam logic [WORD_W-1:0] QNAN_WORD = 32'h7FC0_0000;
  localparam logic [WORD_W-1:0] SAT_WORD  = '1;

  typedef enum logic [2:0] {
    CLS_NAN, CLS_ZERO, CLS_NEG, CLS_PINF, CLS_EST, CLS_FIX_SAT, CLS_FIX_EST
  } rsq_cls_e;

  // Table entry: upper address bit set = fine range (D = 2^(IDX_W+2)).
  // Largest s with (2s-1)^2 * (2q+1) <= 2^(2*EST_W+3) * D.
  function automatic logic [EST_W-1:0] rsq_entry(input int unsigned addr);
    longint unsigned q2p1;
    longint unsigned lim;
    longint unsigned t;
    logic [EST_W-1:0] res;
    logic found;
    int unsigned fine;
    fine  = (addr >> IDX_W) & 1;
    q2p1  = 64'(2 * ((1 << IDX_W) + (addr % (1 << IDX_W))) + 1);
    lim   = 64'd1 << (2 * EST_W + 3 + IDX_W + 1 + fine);
    res   = '0;
    found = 1'b0;
    for (int s = (1 << (EST_W + 1)) - 1; s >= (1 << EST_W); s--) begin
      t = 64'(2 * s - 1);
      if (!found && (t * t * q2p1 <= lim)) begin
        res   = s[EST_W-1:0];
        found = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
(
  input  logic              mode,
  input  logic [WORD_W-1:0] op,
  output rsq_cls_e          cls,
  output logic              snan,
  output logic [ROM_AW-1:0] rom_addr
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max, exp_zero, frac_zero;

  assign exp_f     = op[WORD_W-2 -: EXP_W];
  assign frac_f    = op[FRAC_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_zero  = ~|exp_f;
  assign frac_zero = ~|frac_f;

  always_comb begin
    snan     = 1'b0;
    cls      = CLS_EST;
    rom_addr = {exp_f[0], frac_f[FRAC_W-1 -: IDX_W]};
    if (mode) begin
      if (op[WORD_W-1]) begin
        cls      = CLS_FIX_EST;
        rom_addr = {1'b0, op[WORD_W-2 -: IDX_W]};
      end else if (op[WORD_W-2]) begin
        cls      = CLS_FIX_EST;
        rom_addr = {1'b1, op[WORD_W-3 -: IDX_W]};
      end else begin
        cls      = CLS_FIX_SAT;
      end
    end else if (exp_max && !frac_zero) begin
      cls  = CLS_NAN;
      snan = ~frac_f[FRAC_W-1];
    end else if (exp_zero && frac_zero) begin
      cls = CLS_ZERO;
    end else if (op[WORD_W-1]) begin
      cls = CLS_NEG;
    end else if (exp_max) begin
      cls = CLS_PINF;
    end
  end
endmodule

// File: rtl/rsq_rom.sv
module rsq_rom
  import rsq_pkg::*;
(
  input  logic [ROM_AW-1:0] addr,
  output logic [EST_W-1:0]  est
);
  logic [EST_W-1:0] table_q [ROM_DEPTH];

  for (genvar k = 0; k < ROM_DEPTH; k++) begin : g_entry
    localparam logic [EST_W-1:0] ENTRY = rsq_entry(k);
    assign table_q[k] = ENTRY;
  end

  assign est = table_q[addr];
endmodule

// File: rtl/rsq_assemble.sv
module rsq_assemble
  import rsq_pkg::*;
(
  input  rsq_cls_e          cls,
  input  logic              snan,
  input  logic [WORD_W-1:0] op,
  input  logic [EST_W-1:0]  est,
  output logic [WORD_W-1:0] result,
  output logic              flag_inv,
  output logic              flag_dz
);
  localparam int DIFF_W = EXP_W + 2;
  logic [DIFF_W-1:0] exp_diff;

  assign exp_diff = DIFF_W'(EXP_BASE) - {2'b00, op[WORD_W-2 -: EXP_W]};

  always_comb begin
    flag_inv = 1'b0;
    flag_dz  = 1'b0;
    result   = '0;
    unique case (cls)
      CLS_NAN:     begin result = QNAN_WORD; flag_inv = snan; end
      CLS_ZERO:    begin result = {op[WORD_W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}}; flag_dz = 1'b1; end
      CLS_NEG:     begin result = QNAN_WORD; flag_inv = 1'b1; end
      CLS_PINF:    result = '0;
      CLS_EST:     result = {1'b0, exp_diff[EXP_W:1], est, {(FRAC_W-EST_W){1'b0}}};
      CLS_FIX_SAT: result = SAT_WORD;
      CLS_FIX_EST: result = {1'b1, est, {(WORD_W-1-EST_W){1'b0}}};
      default:     result = '0;
    endcase
  end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [WORD_W-1:0] in_op,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_divzero
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  rsq_cls_e          cls;
  logic              snan;
  logic [ROM_AW-1:0] rom_addr;
  logic [EST_W-1:0]  est;
  logic [WORD_W-1:0] res_d;
  logic              inv_d, dz_d;
  logic              vld_nx, inv_nx, dz_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  rsq_classify u_cls (.mode(in_mode), .op(in_op), .cls(cls), .snan(snan), .rom_addr(rom_addr));
  rsq_rom      u_rom (.addr(rom_addr), .est(est));
  rsq_assemble u_asm (.cls(cls), .snan(snan), .op(in_op), .est(est),
                      .result(res_d), .flag_inv(inv_d), .flag_dz(dz_d));

  always_comb begin
    vld_nx = in_valid;
    inv_nx = in_valid & inv_d;
    dz_nx  = in_valid & dz_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_divzero <= 1'b0;
    end else begin
      out_valid   <= vld_nx;
      out_invalid <= inv_nx;
      out_divzero <= dz_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      out_result <= '0;
    else if (in_valid) out_result <= res_d;
  end
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_mode,
  input logic [31:0] in_op,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_invalid,
  input logic        out_divzero
);
  logic f_nan, f_zero, f_neg, f_pinf, f_est;
  assign f_nan  = !in_mode && (&in_op[30:23]) && (|in_op[22:0]);
  assign f_zero = !in_mode && (in_op[30:0] == 31'd0);
  assign f_neg  = !in_mode && in_op[31] && !f_nan && !f_zero;
  assign f_pinf = !in_mode && (in_op == 32'h7F80_0000);
  assign f_est  = !in_mode && !in_op[31] && !(&in_op[30:23]) && !f_zero;

  a_r1_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && f_nan |=> out_result == 32'h7FC0_0000 && out_invalid == !$past(in_op[22]));
  a_r2_zero_inf: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && f_zero |=> out_divzero && out_result == {$past(in_op[31]), 31'h7F80_0000});
  a_r3_neg_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && f_neg |=> out_invalid && out_result == 32'h7FC0_0000);
  a_r4_pinf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && f_pinf |=> out_result == 32'd0 && !out_invalid && !out_divzero);
  a_r7_exponent: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && f_est |=> out_result[30:23] == 8'((10'd380 - {2'b00, $past(in_op[30:23])}) >> 1)
                          && !out_result[31]);
  a_r8_fix_sat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode && in_op[31:30] == 2'b00 |=> out_result == 32'hFFFF_FFFF);
  a_r8_fix_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode |=> !out_invalid && !out_divzero);
  a_r9_fix_top: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode && in_op[31:30] != 2'b00 |=> out_result[31] && out_result[22:0] == 23'd0);
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_flag_qual: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_invalid && !out_divzero);
endmodule

bind rsqrt_est rsqrt_est_chk chk_i (
  .clk(clk), .rst_n(rst_q_n), .in_valid(in_valid), .in_mode(in_mode), .in_op(in_op),
  .out_valid(out_valid), .out_result(out_result),
  .out_invalid(out_invalid), .out_divzero(out_divzero)
);

// File: tb/rsqrt_est_tb_top.sv
`timescale 1ns/1ps
module rsqrt_est_tb_top;
  logic        clk, rst_n, in_valid, in_mode;
  logic [31:0] in_op, out_result;
  logic        out_valid, out_invalid, out_divzero;
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  rsqrt_est dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
                   .in_op(in_op), .out_valid(out_valid), .out_result(out_result),
                   .out_invalid(out_invalid), .out_divzero(out_divzero));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic int est_s(input int q, input int d);
    real r;
    r = 1.0 / $sqrt((q + 0.5) / d);
    return $rtoi($floor(256.0 * r + 0.5));
  endfunction

  function automatic void ref_model(input logic mode, input logic [31:0] op, output logic [31:0] res,
                                    output logic inv, output logic dz, output string req);
    logic [7:0] e; logic [22:0] f; int s;
    e = op[30:23]; f = op[22:0]; inv = 0; dz = 0;
    if (mode) begin
      if (op[31:30] == 2'b00) begin res = 32'hFFFF_FFFF; req = "R8"; end
      else begin
        if (op[31]) s = est_s(128 + int'(op[30:24]), 256);
        else        s = est_s(128 + int'(op[29:23]), 512);
        res = {1'b1, 8'(s), 23'd0}; req = "R9";
      end
    end else if (e == 8'hFF && f != 0) begin
      res = 32'h7FC0_0000; inv = ~f[22]; req = "R1";
    end else if (e == 0 && f == 0) begin
      res = {op[31], 31'h7F80_0000}; dz = 1; req = "R2";
    end else if (op[31]) begin
      res = 32'h7FC0_0000; inv = 1; req = "R3";
    end else if (e == 8'hFF) begin
      res = 32'd0; req = "R4";
    end else begin
      s = est_s(128 + int'(f[22:16]), e[0] ? 512 : 256);
      res = {1'b0, 8'((380 - int'(e)) / 2), 8'(s), 15'd0}; req = "R6";
    end
  endfunction

  task automatic run_op(input logic mode, input logic [31:0] op);
    logic [31:0] res; logic inv, dz; string req;
    ref_model(mode, op, res, inv, dz, req);
    @(negedge clk);
    in_valid = 1; in_mode = mode; in_op = op;
    @(negedge clk);
    in_valid = 0;
    check("R10", "out_valid", {31'd0, out_valid}, 32'd1);
    if (req == "R6") begin
      check("R7", "exponent", {24'd0, out_result[30:23]}, {24'd0, res[30:23]});
      check("R6", "sign/fraction", {out_result[31], 8'd0, out_result[22:0]}, {res[31], 8'd0, res[22:0]});
    end else begin
      check(req, "result", out_result, res);
    end
    check(req, "invalid", {31'd0, out_invalid}, {31'd0, inv});
    check(req, "divzero", {31'd0, out_divzero}, {31'd0, dz});
  endtask

  task automatic direct(input string req, input logic mode, input logic [31:0] op, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1; in_mode = mode; in_op = op;
    @(negedge clk);
    in_valid = 0;
    check(req, "directed", out_result, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] op; int kind;
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_mode = 0; in_op = '0;
    repeat (3) @(negedge clk);
    check("R10", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R10", "reset flags", {30'd0, out_invalid, out_divzero}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R5 directed range selection, R9 fixed halves, R8 saturation
    direct("R5", 0, 32'h3F80_0000, 32'h3F7F_8000);
    direct("R5", 0, 32'h4080_0000, 32'h3EFF_8000);
    direct("R5", 0, 32'h4000_0000, 32'h3F34_8000);
    direct("R9", 1, 32'h8000_0000, 32'hB480_0000);
    direct("R9", 1, 32'h4000_0000, 32'hFF80_0000);
    direct("R8", 1, 32'h3FFF_FFFF, 32'hFFFF_FFFF);
    // idle after request: no valid, no flags (R10)
    run_op(0, 32'h0000_0000);
    @(negedge clk);
    check("R10", "idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R10", "idle flags", {30'd0, out_invalid, out_divzero}, 32'd0);
    run_op(0, 32'h8000_0000);
    run_op(0, 32'h7FC0_0001);
    run_op(0, 32'h7F80_0001);
    run_op(0, 32'hFFA0_0000);
    run_op(0, 32'h7F80_0000);
    run_op(0, 32'hFF80_0000);
    run_op(0, 32'h8000_0001);
    run_op(0, 32'h0000_0001);
    run_op(0, 32'h007F_FFFF);
    run_op(0, 32'h7F7F_FFFF);
    run_op(1, 32'h0000_0000);
    run_op(1, 32'hFFFF_FFFF);
    for (int i = 0; i < 3000; i++) begin
      kind = $urandom % 8;
      op = $urandom;
      case (kind)
        0: run_op(0, {1'b0, op[30:0]});
        1: run_op(0, {op[31], 8'hFF, op[22], op[21:1], 1'b1});
        2: run_op(0, {op[31], 31'd0});
        3: run_op(0, {1'b1, op[30:0]});
        4: run_op(0, {1'b0, 8'd0, op[22:0]});
        5: run_op(1, op);
        6: run_op(1, {2'b00, op[29:0]});
        default: run_op(0, {1'b0, 7'(op[30:24]), op[23:0]});
      endcase
    end
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule